// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block sits beside the fetch and decode stages and chooses, in the same cycle a branch is decoded, where the next fetch should come from. It keeps no history. Unconditional transfers always go to the target. A conditional branch follows its 2-bit compiler hint when the hint is meaningful. Without a usable hint, it falls back on the sign of the displacement: backward branches, which are usually loop closers, are taken, and forward ones are not.

One cycle after decode, the execute side reports the real outcome of that branch. If the outcome differs from the guess, the block raises a registered flush pulse on the next cycle. Along with the pulse it supplies the corrected fetch address, so the younger instructions that were fetched on the wrong path can be discarded. Two counters track how many conditional branches were resolved and how many of them were mispredicted.

Top module: `branch_dir_predict`

## Requirements
- R1: When `br_valid_i` is low, `pred_taken_o` is 0 and `next_pc_o` equals `pc_i + 4`.
- R2: A valid branch with `br_uncond_i` high is predicted taken, whatever its hint and displacement sign, and `next_pc_o` is the target.
- R3: For a valid conditional branch with hint 2'b00 (none) or 2'b11 (reserved), the prediction is taken exactly when bit DW-1 of the displacement is 1 (negative).
- R4: For a valid conditional branch, hint 2'b10 forces a taken prediction and hint 2'b01 forces not taken, whatever the displacement sign.
- R5: The target is `pc_i + (sign-extended disp_i << 2)` and the sequential address is `pc_i + 4`, both modulo 2^AW; `next_pc_o` is the target when taken and the sequential address otherwise.
- R6: If `res_valid_i` is high in the cycle right after a valid branch was decoded, and `res_taken_i` differs from that branch's prediction, then `flush_o` is high in the following cycle. In that same cycle `redirect_pc_o` holds the branch's target if `res_taken_i` was 1, and its sequential address otherwise.
- R7: If the reported outcome matches the prediction, `flush_o` is low in the following cycle.
- R8: `res_valid_i` in a cycle that does not follow a valid decode is ignored: `flush_o` stays low and the counters do not move.
- R9: `cond_total_o` increments once for each resolved conditional branch, and `cond_miss_o` increments once for each resolved conditional branch that was mispredicted. Unconditional branches are counted in neither.
- R10: While `rst_n` is low at a clock edge, `flush_o` and both counters are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | AW | Address of the decoded instruction |
| br_valid_i | input | 1 | Decoded instruction is a branch |
| br_uncond_i | input | 1 | Branch is unconditional (jump, call, return) |
| disp_i | input | DW | Signed word displacement |
| hint_i | input | 2 | Compiler hint: 00 none, 01 not taken, 10 taken, 11 reserved |
| res_valid_i | input | 1 | Outcome report for the branch decoded last cycle |
| res_taken_i | input | 1 | Actual branch direction |
| pred_taken_o | output | 1 | Predicted direction |
| next_pc_o | output | AW | Next fetch address |
| flush_o | output | 1 | Registered misprediction flush pulse |
| redirect_pc_o | output | AW | Corrected fetch address, valid with flush_o |
| cond_total_o | output | CW | Resolved conditional branch count |
| cond_miss_o | output | CW | Mispredicted conditional branch count |

## Verification
The assertions rely on a one-cycle resolve latency. They assume that an outcome report refers to the branch decoded exactly one cycle earlier, and that the counters never wrap within a run. The stimulus keeps within these limits: each random cycle may decode a branch and may report the outcome of the previous cycle's decode. Reports are also sent after idle cycles on purpose. The runs stay far below 2^CW resolved branches.

// File: rtl/bdp_pkg.sv
// Shared encodings for the static branch direction predictor.
package bdp_pkg;
    // Compiler hint encoding carried with each decoded branch.
    typedef enum logic [1:0] {
        HINT_NONE  = 2'b00,
        HINT_NOT   = 2'b01,
        HINT_TAKE  = 2'b10,
        HINT_RSVD  = 2'b11
    } hint_e;
endpackage

// File: rtl/bdp_addr_gen.sv
// Computes the branch target and the fall-through address.
// Assumes word-aligned instructions (4 bytes) and AW > DW + 2.
module bdp_addr_gen #(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] tgt,
    output logic [AW-1:0] seq
);
    localparam int EXT_W = AW - DW - 2;

    logic [AW-1:0] offs;

    // Sign-extend the word displacement and scale it to bytes.
    always_comb offs = {{EXT_W{disp[DW-1]}}, disp, 2'b00};

    // Both candidate fetch addresses, modulo 2^AW.
    always_comb begin
        tgt = pc + offs;
        seq = pc + AW'(4);
    end
endmodule

// File: rtl/bdp_dir_rule.sv
// Static direction rule: unconditional -> taken; hint when meaningful;
// otherwise backward taken, forward not taken.
// Assumes the inputs are only meaningful while valid is high.
module bdp_dir_rule #(
    parameter bit USE_HINT = 1'b1
) (
    input  logic       valid,
    input  logic       uncond,
    input  logic       disp_neg,
    input  logic [1:0] hint,
    output logic       taken
);
    import bdp_pkg::*;

    logic cond_dir;

    generate
        if (USE_HINT) begin : g_hint
            // Hint overrides the sign rule; none/reserved fall back to it.
            always_comb begin
                unique case (hint_e'(hint))
                    HINT_TAKE: cond_dir = 1'b1;
                    HINT_NOT:  cond_dir = 1'b0;
                    default:   cond_dir = disp_neg;
                endcase
            end
        end else begin : g_sign_only
            logic unused_hint;
            // Sign rule only; the hint is dropped.
            always_comb begin
                cond_dir    = disp_neg;
                unused_hint = ^hint;
            end
        end
    endgenerate

    // Final direction for the decoded instruction.
    always_comb taken = valid && (uncond || cond_dir);
endmodule

// File: rtl/bdp_resolve.sv
// Holds the last decoded branch for one cycle, compares it with the
// reported outcome, and raises a registered flush plus redirect address.
// Assumes the outcome arrives exactly one cycle after decode.
module bdp_resolve #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic          dec_cond,
    input  logic          dec_pred,
    input  logic [AW-1:0] dec_tgt,
    input  logic [AW-1:0] dec_seq,
    input  logic          res_valid,
    input  logic          res_taken,
    output logic          flush,
    output logic [AW-1:0] redirect,
    output logic [CW-1:0] total,
    output logic [CW-1:0] miss
);
    logic          pend_v, pend_cond, pend_pred;
    logic [AW-1:0] pend_tgt, pend_seq;
    logic          resolve, mismatch;

    // An outcome applies only when a branch was decoded last cycle.
    always_comb begin
        resolve  = res_valid && pend_v;
        mismatch = resolve && (res_taken != pend_pred);
    end

    // Record the branch decoded this cycle for next cycle's compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_cond <= 1'b0;
            pend_pred <= 1'b0;
            pend_tgt  <= '0;
            pend_seq  <= '0;
        end else begin
            pend_v <= dec_valid;
            if (dec_valid) begin
                pend_cond <= dec_cond;
                pend_pred <= dec_pred;
                pend_tgt  <= dec_tgt;
                pend_seq  <= dec_seq;
            end
        end
    end

    // Registered flush pulse and corrected address on a mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush    <= 1'b0;
            redirect <= '0;
        end else begin
            flush <= mismatch;
            if (mismatch) redirect <= res_taken ? pend_tgt : pend_seq;
        end
    end

    // Resolved and mispredicted conditional branch counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
            miss  <= '0;
        end else begin
            if (resolve && pend_cond)  total <= total + CW'(1);
            if (mismatch && pend_cond) miss  <= miss + CW'(1);
        end
    end
endmodule

// File: rtl/branch_dir_predict.sv
// Top of the static branch direction predictor: same-cycle direction and
// next fetch address, one-cycle-later resolve with registered flush.
// Assumes pc_i is word aligned and AW > DW + 2.
module branch_dir_predict #(
    parameter int AW       = 32,
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter bit USE_HINT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] pc_i,
    input  logic          br_valid_i,
    input  logic          br_uncond_i,
    input  logic [DW-1:0] disp_i,
    input  logic [1:0]    hint_i,
    input  logic          res_valid_i,
    input  logic          res_taken_i,
    output logic          pred_taken_o,
    output logic [AW-1:0] next_pc_o,
    output logic          flush_o,
    output logic [AW-1:0] redirect_pc_o,
    output logic [CW-1:0] cond_total_o,
    output logic [CW-1:0] cond_miss_o
);
    logic [AW-1:0] tgt, seq;
    logic          taken;

    bdp_addr_gen #(.AW(AW), .DW(DW)) u_addr (
        .pc   (pc_i),
        .disp (disp_i),
        .tgt  (tgt),
        .seq  (seq)
    );

    bdp_dir_rule #(.USE_HINT(USE_HINT)) u_dir (
        .valid    (br_valid_i),
        .uncond   (br_uncond_i),
        .disp_neg (disp_i[DW-1]),
        .hint     (hint_i),
        .taken    (taken)
    );

    bdp_resolve #(.AW(AW), .CW(CW)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_valid (br_valid_i),
        .dec_cond  (!br_uncond_i),
        .dec_pred  (taken),
        .dec_tgt   (tgt),
        .dec_seq   (seq),
        .res_valid (res_valid_i),
        .res_taken (res_taken_i),
        .flush     (flush_o),
        .redirect  (redirect_pc_o),
        .total     (cond_total_o),
        .miss      (cond_miss_o)
    );

    // Steer fetch to the target or the fall-through address.
    always_comb begin
        pred_taken_o = taken;
        next_pc_o    = taken ? tgt : seq;
    end
endmodule

// File: rtl/bdp_checker.sv
// Property checks for branch_dir_predict, attached by bind.
// Assumes outcomes arrive one cycle after decode and counters do not wrap.
module bdp_checker #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] pc_i,
    input logic          br_valid_i,
    input logic          br_uncond_i,
    input logic [1:0]    hint_i,
    input logic          res_valid_i,
    input logic          pred_taken_o,
    input logic [AW-1:0] next_pc_o,
    input logic          flush_o,
    input logic [CW-1:0] cond_total_o,
    input logic [CW-1:0] cond_miss_o
);
    p_idle_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid_i |-> (!pred_taken_o && next_pc_o == pc_i + AW'(4)));

    p_uncond_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && br_uncond_i) |-> pred_taken_o);

    p_hint_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && !br_uncond_i && hint_i == 2'b10) |-> pred_taken_o);

    p_hint_not_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && !br_uncond_i && hint_i == 2'b01) |-> !pred_taken_o);

    p_flush_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && !$past(br_valid_i)) |=> !flush_o);

    p_orphan_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(br_valid_i) |=> $stable(cond_total_o));

    p_miss_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_miss_o != $past(cond_miss_o)) |-> (cond_total_o != $past(cond_total_o)));
endmodule

bind branch_dir_predict bdp_checker #(.AW(AW), .CW(CW)) u_bdp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc_i         (pc_i),
    .br_valid_i   (br_valid_i),
    .br_uncond_i  (br_uncond_i),
    .hint_i       (hint_i),
    .res_valid_i  (res_valid_i),
    .pred_taken_o (pred_taken_o),
    .next_pc_o    (next_pc_o),
    .flush_o      (flush_o),
    .cond_total_o (cond_total_o),
    .cond_miss_o  (cond_miss_o)
);

// File: tb/branch_dir_predict_tb.sv
// Self-checking bench: directed corners then seeded random traffic,
// compared against a bench-side model of the requirements.
module branch_dir_predict_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] pc_i = '0;
    logic          br_valid_i = 1'b0, br_uncond_i = 1'b0;
    logic [DW-1:0] disp_i = '0;
    logic [1:0]    hint_i = '0;
    logic          res_valid_i = 1'b0, res_taken_i = 1'b0;
    logic          pred_taken_o, flush_o;
    logic [AW-1:0] next_pc_o, redirect_pc_o;
    logic [CW-1:0] cond_total_o, cond_miss_o;

    int n_checks = 0;
    int n_fails  = 0;

    // Model state
    logic          e_flush = 0;
    logic [AW-1:0] e_redir = '0;
    int            e_tot = 0, e_miss = 0;
    logic          e_orph = 0;
    logic          p_v = 0, p_cond = 0, p_pred = 0;
    logic [AW-1:0] p_tgt = '0, p_seq = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_dir_predict #(.AW(AW), .DW(DW), .CW(CW)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic f_pred(input logic u, input logic [1:0] h, input logic [DW-1:0] d);
        if (u) return 1'b1;
        if (h == 2'b10) return 1'b1;
        if (h == 2'b01) return 1'b0;
        return d[DW-1];
    endfunction

    function automatic logic [AW-1:0] f_tgt(input logic [AW-1:0] pc, input logic [DW-1:0] d);
        logic signed [AW-1:0] ext;
        ext = AW'($signed(d));
        return pc + (ext <<< 2);
    endfunction

    task automatic step(input logic v, input logic u, input logic [DW-1:0] d, input logic [1:0] h,
                        input logic [AW-1:0] pc, input logic rv, input logic rt);
        logic ep, resolve, mis;
        logic [AW-1:0] en;
        string tag;
        // Registered outputs from the previous edge
        chk(flush_o == e_flush, e_flush ? "R6 flush" : (e_orph ? "R8 orphan" : "R7 no flush"), 64'(flush_o), 64'(e_flush));
        if (e_flush) chk(redirect_pc_o == e_redir, "R6 redirect", 64'(redirect_pc_o), 64'(e_redir));
        chk(cond_total_o == CW'(e_tot), "R9 total", 64'(cond_total_o), 64'(e_tot));
        chk(cond_miss_o == CW'(e_miss), "R9 miss", 64'(cond_miss_o), 64'(e_miss));
        // Drive this cycle
        br_valid_i = v; br_uncond_i = u; disp_i = d; hint_i = h; pc_i = pc;
        res_valid_i = rv; res_taken_i = rt;
        #1;
        ep = v ? f_pred(u, h, d) : 1'b0;
        en = ep ? f_tgt(pc, d) : pc + AW'(4);
        if (!v) tag = "R1";
        else if (u) tag = "R2";
        else if (h == 2'b01 || h == 2'b10) tag = "R4";
        else tag = "R3";
        chk(pred_taken_o == ep, {tag, " direction"}, 64'(pred_taken_o), 64'(ep));
        chk(next_pc_o == en, {tag, " R5 next pc"}, 64'(next_pc_o), 64'(en));
        // Model update for the coming edge
        resolve = rv && p_v;
        mis = resolve && (rt != p_pred);
        e_orph = rv && !p_v;
        e_flush = mis;
        if (mis) e_redir = rt ? p_tgt : p_seq;
        if (resolve && p_cond) e_tot++;
        if (mis && p_cond) e_miss++;
        p_v = v;
        if (v) begin
            p_cond = !u; p_pred = ep; p_tgt = f_tgt(pc, d); p_seq = pc + AW'(4);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        res_valid_i = 1'b1; res_taken_i = 1'b1; br_valid_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(flush_o == 1'b0, "R10 flush", 64'(flush_o), 64'd0);
        chk(cond_total_o == '0, "R10 total", 64'(cond_total_o), 64'd0);
        chk(cond_miss_o == '0, "R10 miss", 64'(cond_miss_o), 64'd0);
        rst_n = 1'b1;
        br_valid_i = 1'b0; res_valid_i = 1'b0;
        @(posedge clk); @(negedge clk);

        // Directed corners
        step(1, 1, 16'h0005, 2'b01, 32'h0000_1000, 0, 0); // R2 uncond despite hint/forward
        step(1, 0, 16'hFFFE, 2'b11, 32'h0000_2000, 1, 1); // R3 reserved hint backward; resolve match
        step(1, 0, 16'hFFF0, 2'b01, 32'h0000_3000, 1, 0); // R4 hint not; previous mispredicted -> R6
        step(1, 0, 16'h0010, 2'b10, 32'h0000_4000, 1, 1); // R4 hint take; prior actually taken -> R6 tgt
        step(1, 0, 16'h8000, 2'b00, 32'h0000_0000, 1, 0); // R5 wrap; prior mispredicted
        step(1, 0, 16'h7FFF, 2'b00, 32'hFFFF_FFFC, 1, 1); // R3 forward not taken; prior match
        step(0, 0, 16'h0000, 2'b00, 32'h0000_5000, 1, 1); // R6 prior mispredicted
        step(0, 0, 16'h0000, 2'b00, 32'h0000_6000, 1, 0); // R8 orphan resolve
        step(1, 1, 16'hFFFF, 2'b00, 32'h0000_7000, 0, 0);
        step(0, 0, 16'h0000, 2'b00, 32'h0000_7004, 1, 0); // uncond mispredicted: R6, not R9-counted

        // Seeded random traffic
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom), 1'($urandom_range(0, 3) == 0), DW'($urandom), 2'($urandom),
                 AW'($urandom) & ~AW'(3), 1'($urandom_range(0, 3) != 0), 1'($urandom));
        end
        step(0, 0, '0, 2'b00, '0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule